// File: doc/BRIEF.md
# Standby Sequencer with Status-Flag Gated Entry

This block decides when a small 4-bit controller core sleeps and when it wakes. The core reports an executed standby instruction as a one-cycle strobe together with a 4-bit operand. Operand bit 3 picks the depth of sleep. In light standby the core clock stops and the oscillator keeps running. In deep standby the oscillator stops as well. Operand bits 1 and 0 enable the wake sources: the timer expiry and any active key input.

Entry is gated by a single status flag. The core only goes to sleep when the flag is clear and no enabled wake source is already active. In every other case the instruction falls through and only updates the flag. A status-test strobe loads the flag from a chosen source, so software can clear it just before issuing the standby instruction. On wake-up the block emits a one-cycle resume pulse and an address select. The select chooses the next instruction after a wake by a source, and address zero after a power-on clear.

States: `ST_PORC` is held during and just after power-on clear. `ST_RUN` is normal execution. `ST_HALT` is light standby. `ST_STOP` is deep standby. Transitions:
- `ST_PORC` to `ST_RUN` on the first edge after reset is released (reset wake).
- `ST_RUN` to `ST_HALT` or `ST_STOP` on an accepted standby instruction (entry).
- `ST_HALT` or `ST_STOP` back to `ST_RUN` when the wake condition is true (source wake).
- Any state to `ST_PORC` on an asynchronous reset.

Top module: `standby_ctrl`

## Requirements
- R1: Operand bit 3 = 1 selects deep standby and 0 selects light standby. Bit 0 enables key wake, where key activity means any bit of `key_in` is high. Bit 1 enables timer wake. Bit 2 has no effect. The wake condition is the OR of the enabled sources.
- R2: A standby strobe in `ST_RUN` with the flag at 0 and the wake condition false enters standby on that edge. From the next cycle, light standby shows `core_clk_en`=0 and `osc_en`=1, and deep standby shows both at 0. The flag stays 0.
- R3: A standby strobe with the flag at 1 does not enter standby. The flag takes the value of the wake condition.
- R4: A standby strobe with the flag at 0 and the wake condition already true does not enter standby and sets the flag to 1.
- R5: In light standby, a true wake condition at a clock edge returns the core to `ST_RUN` on that edge. `core_clk_en`=1, `resume_pls`=1, `resume_next`=1 and `flag_f`=1 are all visible in the following cycle. With no wake condition the block stays asleep.
- R6: The timer is never counted as a wake source for deep standby, neither when the standby instruction is issued nor while asleep. Only a key wake (or reset) ends deep standby.
- R7: A status-test strobe in `ST_RUN` loads the flag from key activity when `tst_sel`=0 and from `tmr_exp` when `tst_sel`=1. If it arrives in the same cycle as a standby strobe, the test strobe is ignored.
- R8: An active-low `rst_n` at once forces flag 0, `core_clk_en`=0, `resume_pls`=0 and `osc_en`=1. On the first edge after release the block reports `resume_pls`=1, `resume_next`=0, `flag_f`=1 and `core_clk_en`=1.
- R9: `resume_pls` is high for exactly one cycle per wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on clear, active low |
| halt_stb | input | 1 | Standby instruction executed (one cycle) |
| halt_opnd | input | 4 | Standby operand: bit 3 depth, bits 1..0 wake enables |
| tst_stb | input | 1 | Status-test instruction executed |
| tst_sel | input | 1 | Status-test source: 0 key activity, 1 timer expiry |
| key_in | input | KEY_W | Key input lines, high = active |
| tmr_exp | input | 1 | Timer expiry level |
| core_clk_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Oscillator enable |
| resume_pls | output | 1 | One-cycle wake-up pulse |
| resume_next | output | 1 | Resume address: 1 next instruction, 0 address zero |
| flag_f | output | 1 | Status flag |

## Verification
Suppose the stored depth or the wake mask is wrong. That shows up within one cycle of the standby strobe on `osc_en`. It also shows up on the first wake edge, as a missing or spurious `resume_pls`. A flag update that takes the wrong branch shows on `flag_f` and `core_clk_en` in the cycle right after the strobe. A mis-sequenced reset exit shows on the first edge after `rst_n` rises, through `resume_next` and the length of the pulse.

// File: rtl/stby_pkg.sv
package stby_pkg;
    typedef enum logic [1:0] {
        ST_PORC = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2,
        ST_STOP = 2'd3
    } stby_state_t;

    localparam int OPND_W   = 4;
    localparam int OP_KEY   = 0;
    localparam int OP_TMR   = 1;
    localparam int OP_DEEP  = 3;
endpackage

// File: rtl/stby_cond.sv
module stby_cond
    import stby_pkg::*;
#(
    parameter int KEY_W = 4
) (
    input  logic [KEY_W-1:0]  key_in,
    input  logic              tmr_exp,
    input  logic [OPND_W-1:0] live_opnd,
    input  logic [OPND_W-1:0] held_opnd,
    input  logic              use_held,
    output logic              key_any,
    output logic              rel_cond
);
    logic [KEY_W-1:0]  or_chain;
    logic [OPND_W-1:0] opnd;
    logic              deep;

    assign or_chain[0] = key_in[0];
    generate
        for (genvar i = 1; i < KEY_W; i++) begin : g_key_or
            assign or_chain[i] = or_chain[i-1] | key_in[i];
        end
    endgenerate
    assign key_any = or_chain[KEY_W-1];

    always_comb begin
        opnd     = use_held ? held_opnd : live_opnd;
        deep     = opnd[OP_DEEP];
        // timer never counts toward a deep-standby wake
        rel_cond = (opnd[OP_KEY] & key_any)
                 | (opnd[OP_TMR] & tmr_exp & ~deep);
    end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_stb,
    input  logic [OPND_W-1:0] halt_opnd,
    input  logic              tst_stb,
    input  logic              tst_sel,
    input  logic              key_any,
    input  logic              tmr_exp,
    input  logic              rel_cond,
    output stby_state_t       st_q,
    output logic [OPND_W-1:0] held_opnd,
    output logic              flag_q,
    output logic              resume_pls,
    output logic              resume_next
);
    stby_state_t       st_d;
    logic [OPND_W-1:0] opnd_d;
    logic              flag_d, pls_d, nxt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_PORC;
            held_opnd   <= '0;
            flag_q      <= 1'b0;
            resume_pls  <= 1'b0;
            resume_next <= 1'b0;
        end else begin
            st_q        <= st_d;
            held_opnd   <= opnd_d;
            flag_q      <= flag_d;
            resume_pls  <= pls_d;
            resume_next <= nxt_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        opnd_d = held_opnd;
        flag_d = flag_q;
        pls_d  = 1'b0;
        nxt_d  = resume_next;
        unique case (st_q)
            ST_PORC: begin
                st_d   = ST_RUN;
                flag_d = 1'b1;
                pls_d  = 1'b1;
                nxt_d  = 1'b0;
            end
            ST_RUN: begin
                if (halt_stb) begin
                    if (flag_q) begin
                        flag_d = rel_cond;
                    end else if (rel_cond) begin
                        flag_d = 1'b1;
                    end else begin
                        opnd_d = halt_opnd;
                        st_d   = halt_opnd[OP_DEEP] ? ST_STOP : ST_HALT;
                    end
                end else if (tst_stb) begin
                    flag_d = tst_sel ? tmr_exp : key_any;
                end
            end
            ST_HALT, ST_STOP: begin
                if (rel_cond) begin
                    st_d   = ST_RUN;
                    flag_d = 1'b1;
                    pls_d  = 1'b1;
                    nxt_d  = 1'b1;
                end
            end
            default: st_d = ST_PORC;
        endcase
    end

    // R3
    property p_busy_flag;
        @(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && halt_stb && flag_q) |=> (st_q == ST_RUN && flag_q == $past(rel_cond));
    endproperty
    flag_set_no_entry_chk: assert property (p_busy_flag);

    // R4
    property p_early_wake;
        @(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && halt_stb && rel_cond) |=> (st_q == ST_RUN && flag_q);
    endproperty
    cond_met_no_entry_chk: assert property (p_early_wake);

    // R5
    property p_wake;
        @(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT && rel_cond) |=> (resume_pls && resume_next && flag_q);
    endproperty
    halt_wake_chk: assert property (p_wake);

    // R6
    property p_deep_key_only;
        @(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP && !key_any) |=> !resume_pls;
    endproperty
    stop_key_only_chk: assert property (p_deep_key_only);

    // R8
    property p_reset_exit;
        @(posedge clk) disable iff (!rst_n)
        (st_q == ST_PORC) |=> (resume_pls && !resume_next && flag_q);
    endproperty
    reset_resume_chk: assert property (p_reset_exit);

    // R9
    property p_single_pulse;
        @(posedge clk) disable iff (!rst_n)
        resume_pls |=> !resume_pls;
    endproperty
    one_cycle_pulse_chk: assert property (p_single_pulse);
endmodule

// File: rtl/stby_outs.sv
module stby_outs
    import stby_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  stby_state_t st_q,
    input  logic        resume_pls,
    output logic        core_clk_en,
    output logic        osc_en
);
    always_comb begin
        core_clk_en = 1'b0;
        osc_en      = 1'b1;
        unique case (st_q)
            ST_PORC: core_clk_en = 1'b0;
            ST_RUN:  core_clk_en = 1'b1;
            ST_HALT: core_clk_en = 1'b0;
            ST_STOP: osc_en      = 1'b0;
            default: core_clk_en = 1'b0;
        endcase
    end

    // R5
    property p_pulse_running;
        @(posedge clk) disable iff (!rst_n)
        resume_pls |-> core_clk_en;
    endproperty
    pulse_clk_on_chk: assert property (p_pulse_running);
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
    import stby_pkg::*;
#(
    parameter int KEY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_stb,
    input  logic [3:0]       halt_opnd,
    input  logic             tst_stb,
    input  logic             tst_sel,
    input  logic [KEY_W-1:0] key_in,
    input  logic             tmr_exp,
    output logic             core_clk_en,
    output logic             osc_en,
    output logic             resume_pls,
    output logic             resume_next,
    output logic             flag_f
);
    stby_state_t       st_q;
    logic [OPND_W-1:0] held_opnd;
    logic              key_any, rel_cond, use_held;

    assign use_held = (st_q != ST_RUN);

    stby_cond #(.KEY_W(KEY_W)) u_cond (
        .key_in    (key_in),
        .tmr_exp   (tmr_exp),
        .live_opnd (halt_opnd),
        .held_opnd (held_opnd),
        .use_held  (use_held),
        .key_any   (key_any),
        .rel_cond  (rel_cond)
    );

    stby_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_stb    (halt_stb),
        .halt_opnd   (halt_opnd),
        .tst_stb     (tst_stb),
        .tst_sel     (tst_sel),
        .key_any     (key_any),
        .tmr_exp     (tmr_exp),
        .rel_cond    (rel_cond),
        .st_q        (st_q),
        .held_opnd   (held_opnd),
        .flag_q      (flag_f),
        .resume_pls  (resume_pls),
        .resume_next (resume_next)
    );

    stby_outs u_outs (
        .clk         (clk),
        .rst_n       (rst_n),
        .st_q        (st_q),
        .resume_pls  (resume_pls),
        .core_clk_en (core_clk_en),
        .osc_en      (osc_en)
    );
endmodule

// File: tb/standby_ctrl_test.sv
module standby_ctrl_test;
    localparam int KEY_W = 4;
    localparam int NV    = 9;
    // {finit, opnd[3:0], key, tmr, enter, expf, osc}
    localparam logic [9:0] VEC [0:NV-1] = '{
        10'b0_0011_0_0_1_0_1,
        10'b0_1001_0_0_1_0_0,
        10'b1_0001_0_0_0_0_1,
        10'b1_0001_1_0_0_1_1,
        10'b0_0001_1_0_0_1_1,
        10'b0_0010_0_1_0_1_1,
        10'b0_1011_0_1_1_0_0,
        10'b1_0010_0_1_0_1_1,
        10'b0_0101_0_0_1_0_1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_stb = 1'b0;
    logic [3:0] halt_opnd = '0;
    logic tst_stb = 1'b0;
    logic tst_sel = 1'b0;
    logic [KEY_W-1:0] key_in = '0;
    logic tmr_exp = 1'b0;
    logic core_clk_en, osc_en, resume_pls, resume_next, flag_f;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    standby_ctrl #(.KEY_W(KEY_W)) uut (
        .clk(clk), .rst_n(rst_n), .halt_stb(halt_stb), .halt_opnd(halt_opnd),
        .tst_stb(tst_stb), .tst_sel(tst_sel), .key_in(key_in), .tmr_exp(tmr_exp),
        .core_clk_en(core_clk_en), .osc_en(osc_en), .resume_pls(resume_pls),
        .resume_next(resume_next), .flag_f(flag_f)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_flag(input logic v);
        key_in = v ? '1 : '0;
        tst_sel = 1'b0;
        tst_stb = 1'b1;
        step();
        tst_stb = 1'b0;
        key_in = '0;
    endtask

    task automatic issue(input logic [3:0] op, input logic k, input logic t);
        halt_opnd = op;
        key_in = k ? 4'b0100 : '0;
        tmr_exp = t;
        halt_stb = 1'b1;
        step();
        halt_stb = 1'b0;
        key_in = '0;
        tmr_exp = 1'b0;
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        // R8 reset state
        chk("R8 rst flag", flag_f, 0);
        chk("R8 rst clk_en", core_clk_en, 0);
        chk("R8 rst pulse", resume_pls, 0);
        chk("R8 rst osc", osc_en, 1);
        #10;
        rst_n = 1'b1;
        step();
        chk("R8 exit pulse", resume_pls, 1);
        chk("R8 exit addr0", resume_next, 0);
        chk("R8 exit flag", flag_f, 1);
        step();
        chk("R9 pulse drop", resume_pls, 0);

        for (int i = 0; i < NV; i++) begin
            logic [9:0] v;
            v = VEC[i];
            set_flag(v[9]);
            chk("R7 test key", flag_f, v[9]);
            issue(v[8:5], v[4], v[3]);
            // R1 R2 R3 R4 R6: entry decision and resulting flag
            chk("R2/R3/R4 clk_en", core_clk_en, !v[2]);
            chk("R3/R4 flag", flag_f, v[1]);
            chk("R1 depth osc", osc_en, v[0]);
            if (v[2]) begin
                step();
                chk("R2 stays asleep", core_clk_en, 0);
                key_in = 4'b0001;
                step();
                key_in = '0;
                chk("R5 key wake pulse", resume_pls, 1);
                chk("R5 wake next", resume_next, 1);
                chk("R5 wake flag", flag_f, 1);
                chk("R5 wake clk", core_clk_en, 1);
                step();
                chk("R9 one cycle", resume_pls, 0);
            end
        end

        // R5 timer wake from light standby
        set_flag(1'b0);
        issue(4'b0010, 1'b0, 1'b0);
        chk("R5 timer entry", core_clk_en, 0);
        step();
        step();
        chk("R5 no spurious wake", resume_pls, 0);
        tmr_exp = 1'b1;
        step();
        tmr_exp = 1'b0;
        chk("R5 timer wake pulse", resume_pls, 1);
        chk("R5 timer wake next", resume_next, 1);

        // R6 timer ignored in deep standby
        set_flag(1'b0);
        issue(4'b1011, 1'b0, 1'b0);
        chk("R6 deep osc", osc_en, 0);
        tmr_exp = 1'b1;
        for (int j = 0; j < 3; j++) begin
            step();
            chk("R6 timer ignored clk", core_clk_en, 0);
            chk("R6 timer ignored pulse", resume_pls, 0);
        end
        tmr_exp = 1'b0;
        key_in = 4'b1000;
        step();
        key_in = '0;
        chk("R6 key wake", resume_pls, 1);

        // R7 test strobe with timer source
        tmr_exp = 1'b1;
        tst_sel = 1'b1;
        tst_stb = 1'b1;
        step();
        chk("R7 timer into flag", flag_f, 1);
        tmr_exp = 1'b0;
        step();
        tst_stb = 1'b0;
        chk("R7 timer low into flag", flag_f, 0);

        // R7 standby strobe wins over test strobe
        halt_opnd = 4'b0001;
        tmr_exp = 1'b1;
        tst_sel = 1'b1;
        tst_stb = 1'b1;
        halt_stb = 1'b1;
        step();
        halt_stb = 1'b0;
        tst_stb = 1'b0;
        tmr_exp = 1'b0;
        chk("R7 priority flag", flag_f, 0);
        chk("R7 priority entry", core_clk_en, 0);

        // R8 reset during standby
        #1;
        rst_n = 1'b0;
        #1;
        chk("R8 async flag", flag_f, 0);
        chk("R8 async clk_en", core_clk_en, 0);
        chk("R8 async osc", osc_en, 1);
        chk("R8 async pulse", resume_pls, 0);
        step();
        rst_n = 1'b1;
        step();
        chk("R8 standby reset pulse", resume_pls, 1);
        chk("R8 standby reset addr0", resume_next, 0);
        chk("R8 standby reset flag", flag_f, 1);
        chk("R8 standby reset clk", core_clk_en, 1);
        step();
        chk("R9 reset pulse drop", resume_pls, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule